// File: doc/BRIEF.md
# Split Serial Register Pointer Controller

This block produces the read address for a 256-word serial output buffer. The buffer is split into a low half (words 0–127) and a high half (words 128–255). A host issues transfer requests that carry a column value. The column's top bit picks which half of the source row is moved. Its lower bits give the start position (tap) of the serial stream. Each serial clock tick moves the pointer by one word. The block tells the buffer storage which part to reload through a one-cycle load request.

There are two kinds of transfer. A full transfer reloads the whole buffer and places the pointer at any of the 256 taps; streaming then runs linearly and wraps. A split transfer reloads only the half the pointer is not in, so the stream never stalls. When the active half (or the active segment, once a stop code is programmed) is used up, the pointer jumps to the other half at the offset given by the last split transfer.

A half-status flag reports which half is being read. A serial enable drives the data outputs and the flag to high impedance but never stops the pointer.

Top module: `split_ptr_ctrl`

## Requirements
- R1: After reset the buffer address is 0, the half flag (when enabled) is 0, and neither a load request nor an error is raised.
- R2: A full transfer (request with split=0) sets the address to column bits 7..0 at the next edge. In the same cycle it raises the load request with the full indicator set and row-half equal to column bit 8.
- R3: Outside a hop, each serial tick adds one to the address, wrapping 255 to 0. The half flag always equals address bit 7, so it toggles when the address goes 127→128 and 255→0.
- R4: An accepted split transfer raises a load request with full=0, target half equal to the inverse of the current address bit 7, and row-half equal to column bit 8. It does not move the pointer, and column bit 7 has no effect.
- R5: In split mode, a tick on the last word of the active segment moves the address to the other half, at the offset (column bits 6..0) of the latest split transfer.
- R6: After a hop, the stored offset returns to 0. A later hop with no new split transfer in between enters the other half at offset 0.
- R7: A split request made before any full transfer, or one whose offset bits 6..0 are all ones (word 127 or 255), raises the error output for one cycle. It raises no load request and leaves the pointer and mode unchanged.
- R8: A stop code k (values above 6 act as 6) splits each half into segments of 128>>k words. In split mode the end of each segment triggers the hop of R5. In full mode the stop code has no effect.
- R9: The stop-clear input returns the stop code to 0 (whole-half segments). It wins over a stop-set in the same cycle.
- R10: While the serial enable is high, the data outputs and the half flag are high impedance, and ticks still advance the address.
- R11: A full transfer in the same cycle as a tick takes priority over the tick. A full transfer also leaves split mode, so later ticks count linearly even with a stop code set.
- R12: While the serial enable is low, the data outputs carry the buffer word at the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_tick | input | 1 | One-cycle serial clock advance pulse |
| xfer_req | input | 1 | Transfer request pulse |
| xfer_split | input | 1 | 1: split transfer, 0: full transfer |
| xfer_col | input | ADDR_W+1 | Bit 8 row-half select, bits 7..0 tap |
| stop_set | input | 1 | Load the stop code |
| stop_code | input | STOP_W | Segment code |
| stop_clear | input | 1 | Reset-variant refresh: clear the stop code |
| ser_en_n | input | 1 | Active-low serial output enable |
| buf_addr | output | ADDR_W | Buffer read address |
| buf_rdata | input | DATA_W | Word read from the buffer |
| ser_dout | output | DATA_W | Tri-stated serial data |
| half_flag | output | 1 | Tri-stated half status |
| ld_valid | output | 1 | Buffer load request |
| ld_full | output | 1 | Load covers the whole buffer |
| ld_half | output | 1 | Target half of a split load |
| ld_row_hi | output | 1 | Source row half for the load |
| split_err | output | 1 | Rejected split request pulse |

## Verification
Full transfers are tried at taps near 127 and 255, which separates plain linear counting and wrap from the half-flag toggle. Split transfers are given offsets with column bit 7 set, so an ignored bit cannot be mistaken for a used one. Hops are run both with a freshly loaded offset and with none, which separates entry at the loaded tap from entry at offset 0. Stop codes 2, 9 (clamped) and a clear that collides with a set show where a segment ends. A full transfer sharing a cycle with a tick, followed by a run through a would-be segment end, shows priority and the exit from split mode.

// File: rtl/split_ptr_pkg.sv
package split_ptr_pkg;

  typedef enum logic [1:0] {
    RK_IDLE,
    RK_FULL,
    RK_SPLIT,
    RK_REJECT
  } req_kind_e;

  typedef struct packed {
    logic valid;
    logic full;
    logic half;
    logic row_hi;
  } ld_req_t;

endpackage

// File: rtl/split_ptr_rst_sync.sv
module split_ptr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_n_sync <= meta_q;
    end
  end
endmodule

// File: rtl/split_ptr_req_dec.sv
module split_ptr_req_dec
  import split_ptr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              split,
  input  logic [ADDR_W:0]   col,
  input  logic              cur_half,
  output req_kind_e         kind,
  output logic [ADDR_W-1:0] tap,
  output ld_req_t           ld,
  output logic              err
);
  localparam int OFF_W = ADDR_W - 1;

  logic    setup_q;
  logic    setup_en;
  ld_req_t ld_d;
  logic    err_d;

  // classify the incoming request
  always_comb begin
    kind = RK_IDLE;
    if (req) begin
      if (!split)                                kind = RK_FULL;
      else if (!setup_q || (&col[OFF_W-1:0]))    kind = RK_REJECT;
      else                                       kind = RK_SPLIT;
    end
  end

  assign tap = col[ADDR_W-1:0];

  // next-state for the load request bundle and error pulse
  always_comb begin
    setup_en    = (kind == RK_FULL);
    ld_d.valid  = (kind == RK_FULL) || (kind == RK_SPLIT);
    ld_d.full   = (kind == RK_FULL);
    ld_d.half   = (kind == RK_SPLIT) ? ~cur_half : 1'b0;
    ld_d.row_hi = ld_d.valid & col[ADDR_W];
    err_d       = (kind == RK_REJECT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q <= 1'b0;
      ld      <= '0;
      err     <= 1'b0;
    end else begin
      if (setup_en) setup_q <= 1'b1;
      ld  <= ld_d;
      err <= err_d;
    end
  end
endmodule

// File: rtl/split_ptr_core.sv
module split_ptr_core #(
  parameter int ADDR_W = 8,
  parameter int STOP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              full_go,
  input  logic              split_go,
  input  logic [ADDR_W-1:0] tap,
  input  logic              stop_set,
  input  logic [STOP_W-1:0] stop_code,
  input  logic              stop_clear,
  output logic [ADDR_W-1:0] ptr,
  output logic              hop_now
);
  localparam int OFF_W  = ADDR_W - 1;
  localparam int SH_W   = (OFF_W > 1) ? $clog2(OFF_W) : 1;
  localparam int SH_MAX = OFF_W - 1;

  logic              split_mode_q, split_mode_d;
  logic [OFF_W-1:0]  hop_tap_q, hop_tap_d;
  logic [SH_W-1:0]   stop_k_q, stop_k_d;
  logic [ADDR_W-1:0] ptr_d;
  logic              ptr_en, mode_en, hop_en, stop_en;
  logic [OFF_W-1:0]  seg_mask;
  logic              seg_end;
  logic [OFF_W-1:0]  hop_off;
  logic [SH_W-1:0]   stop_clamped;

  // segment end detection from the programmed stop code
  always_comb begin
    seg_mask = {OFF_W{1'b1}} >> stop_k_q;
    seg_end  = ((ptr[OFF_W-1:0] & seg_mask) == seg_mask);
    hop_now  = split_mode_q & seg_end;
    hop_off  = split_go ? tap[OFF_W-1:0] : hop_tap_q;
  end

  // pointer next state
  always_comb begin
    ptr_en = full_go | tick;
    ptr_d  = ptr;
    if (full_go)      ptr_d = tap;
    else if (tick) begin
      if (hop_now)    ptr_d = {~ptr[ADDR_W-1], hop_off};
      else            ptr_d = ptr + 1'b1;
    end
  end

  // mode and stored hop offset next state
  always_comb begin
    mode_en      = full_go | split_go;
    split_mode_d = split_go;
    hop_en       = full_go | split_go | (tick & hop_now);
    hop_tap_d    = hop_tap_q;
    if (full_go || (tick && hop_now)) hop_tap_d = '0;
    else if (split_go)                hop_tap_d = tap[OFF_W-1:0];
  end

  // stop code next state, clear has priority
  always_comb begin
    stop_clamped = (stop_code > STOP_W'(SH_MAX)) ? SH_W'(SH_MAX) : SH_W'(stop_code);
    stop_en      = stop_set | stop_clear;
    stop_k_d     = stop_clear ? '0 : stop_clamped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr          <= '0;
      split_mode_q <= 1'b0;
      hop_tap_q    <= '0;
      stop_k_q     <= '0;
    end else begin
      if (ptr_en)  ptr          <= ptr_d;
      if (mode_en) split_mode_q <= split_mode_d;
      if (hop_en)  hop_tap_q    <= hop_tap_d;
      if (stop_en) stop_k_q     <= stop_k_d;
    end
  end
endmodule

// File: rtl/split_ptr_out_gate.sv
module split_ptr_out_gate #(
  parameter int DATA_W = 16
) (
  input  logic              ser_en_n,
  input  logic [DATA_W-1:0] buf_rdata,
  input  logic              half_raw,
  output wire  [DATA_W-1:0] ser_dout,
  output wire               half_flag
);
  for (genvar g = 0; g < DATA_W; g++) begin : g_dq
    assign ser_dout[g] = ser_en_n ? 1'bz : buf_rdata[g];
  end

  assign half_flag = ser_en_n ? 1'bz : half_raw;
endmodule

// File: rtl/split_ptr_ctrl.sv
module split_ptr_ctrl
  import split_ptr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int STOP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_tick,
  input  logic              xfer_req,
  input  logic              xfer_split,
  input  logic [ADDR_W:0]   xfer_col,
  input  logic              stop_set,
  input  logic [STOP_W-1:0] stop_code,
  input  logic              stop_clear,
  input  logic              ser_en_n,
  output logic [ADDR_W-1:0] buf_addr,
  input  logic [DATA_W-1:0] buf_rdata,
  output wire  [DATA_W-1:0] ser_dout,
  output wire               half_flag,
  output logic              ld_valid,
  output logic              ld_full,
  output logic              ld_half,
  output logic              ld_row_hi,
  output logic              split_err
);
  logic              rst_sync_n;
  req_kind_e         kind;
  logic [ADDR_W-1:0] tap;
  ld_req_t           ld;
  logic              hop_now;
  logic              full_go, split_go;

  split_ptr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_sync_n)
  );

  split_ptr_req_dec #(.ADDR_W(ADDR_W)) u_dec (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .req      (xfer_req),
    .split    (xfer_split),
    .col      (xfer_col),
    .cur_half (buf_addr[ADDR_W-1]),
    .kind     (kind),
    .tap      (tap),
    .ld       (ld),
    .err      (split_err)
  );

  assign full_go  = (kind == RK_FULL);
  assign split_go = (kind == RK_SPLIT);

  split_ptr_core #(.ADDR_W(ADDR_W), .STOP_W(STOP_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick       (sclk_tick),
    .full_go    (full_go),
    .split_go   (split_go),
    .tap        (tap),
    .stop_set   (stop_set),
    .stop_code  (stop_code),
    .stop_clear (stop_clear),
    .ptr        (buf_addr),
    .hop_now    (hop_now)
  );

  split_ptr_out_gate #(.DATA_W(DATA_W)) u_gate (
    .ser_en_n  (ser_en_n),
    .buf_rdata (buf_rdata),
    .half_raw  (buf_addr[ADDR_W-1]),
    .ser_dout  (ser_dout),
    .half_flag (half_flag)
  );

  assign ld_valid  = ld.valid;
  assign ld_full   = ld.full;
  assign ld_half   = ld.half;
  assign ld_row_hi = ld.row_hi;
endmodule

// File: rtl/split_ptr_ctrl_chk.sv
module split_ptr_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              sclk_tick,
  input logic              xfer_req,
  input logic              xfer_split,
  input logic [ADDR_W:0]   xfer_col,
  input logic [ADDR_W-1:0] buf_addr,
  input logic              ld_valid,
  input logic              ld_full,
  input logic              ld_half,
  input logic              split_err,
  input logic              hop_now
);
  localparam int MSB = ADDR_W - 1;

  assert_full_load_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (xfer_req && !xfer_split) |=>
      (buf_addr == $past(xfer_col[ADDR_W-1:0])) && ld_valid && ld_full);

  assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sclk_tick && !(xfer_req && !xfer_split) && !hop_now) |=>
      (buf_addr == ADDR_W'($past(buf_addr) + 1'b1)));

  assert_split_target_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (xfer_req && xfer_split) |=> (!ld_valid || (!ld_full && ld_half != $past(buf_addr[MSB]))));

  assert_hop_half_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sclk_tick && !(xfer_req && !xfer_split) && hop_now) |=>
      (buf_addr[MSB] != $past(buf_addr[MSB])));

  assert_err_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({ld_valid, split_err}));

  assert_err_no_move_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (xfer_req && xfer_split && !sclk_tick) |=> (!split_err || $stable(buf_addr)));
endmodule

bind split_ptr_ctrl split_ptr_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .sclk_tick  (sclk_tick),
  .xfer_req   (xfer_req),
  .xfer_split (xfer_split),
  .xfer_col   (xfer_col),
  .buf_addr   (buf_addr),
  .ld_valid   (ld_valid),
  .ld_full    (ld_full),
  .ld_half    (ld_half),
  .split_err  (split_err),
  .hop_now    (hop_now)
);

// File: tb/tb_split_ptr_ctrl.sv
module tb_split_ptr_ctrl;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int STOP_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sclk_tick = 1'b0;
  logic              xfer_req = 1'b0;
  logic              xfer_split = 1'b0;
  logic [ADDR_W:0]   xfer_col = '0;
  logic              stop_set = 1'b0;
  logic [STOP_W-1:0] stop_code = '0;
  logic              stop_clear = 1'b0;
  logic              ser_en_n = 1'b0;
  logic [ADDR_W-1:0] buf_addr;
  logic [DATA_W-1:0] buf_rdata;
  wire  [DATA_W-1:0] ser_dout;
  wire               half_flag;
  logic              ld_valid, ld_full, ld_half, ld_row_hi, split_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [ADDR_W-1:0] addr;
    bit                en;
    bit                chk_data;
    string             tag;
  } exp_t;
  exp_t expq[$];

  logic [DATA_W-1:0] bmem [DEPTH];
  logic [DATA_W-1:0] emem [DEPTH];
  logic [6:0]        lcount = '0;
  logic [6:0]        egen = '0;
  logic              tick_q = 1'b0;

  always #4 clk = ~clk;

  for (genvar g = 0; g < DATA_W; g++) begin : g_pu
    pullup (ser_dout[g]);
  end
  pullup (half_flag);

  split_ptr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STOP_W(STOP_W)) dut (
    .clk(clk), .rst_n(rst_n), .sclk_tick(sclk_tick), .xfer_req(xfer_req),
    .xfer_split(xfer_split), .xfer_col(xfer_col), .stop_set(stop_set),
    .stop_code(stop_code), .stop_clear(stop_clear), .ser_en_n(ser_en_n),
    .buf_addr(buf_addr), .buf_rdata(buf_rdata), .ser_dout(ser_dout),
    .half_flag(half_flag), .ld_valid(ld_valid), .ld_full(ld_full),
    .ld_half(ld_half), .ld_row_hi(ld_row_hi), .split_err(split_err)
  );

  // buffer storage model driven by the load request outputs
  assign buf_rdata = bmem[buf_addr];
  always @(posedge clk) begin
    tick_q <= sclk_tick;
    if (ld_valid) begin
      lcount <= lcount + 7'd1;
      for (int i = 0; i < DEPTH; i++)
        if (ld_full || (i[7] == ld_half))
          bmem[i] <= {lcount + 7'd1, ld_row_hi, i[7:0]};
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pop one expected item per consumed tick
  always @(negedge clk) begin
    if (tick_q) begin
      if (expq.size() == 0) begin
        chk(1'b0, "scoreboard", 0, 1);
      end else begin
        exp_t it;
        it = expq.pop_front();
        chk(buf_addr == it.addr, it.tag, buf_addr, it.addr);
        if (it.en) begin
          chk(half_flag == it.addr[7], it.tag, half_flag, it.addr[7]);
          if (it.chk_data)
            chk(ser_dout == emem[it.addr], "R12", ser_dout, emem[it.addr]);
        end else begin
          chk(ser_dout == '1, "R10", ser_dout, 16'hffff);
          chk(half_flag == 1'b1, "R10", half_flag, 1);
        end
      end
    end
  end

  task automatic tick_exp(input int a, input string tag);
    exp_t it;
    it.addr = a[ADDR_W-1:0]; it.en = !ser_en_n; it.chk_data = 1'b1; it.tag = tag;
    expq.push_back(it);
    @(negedge clk) sclk_tick = 1'b1;
    @(negedge clk) sclk_tick = 1'b0;
  endtask

  task automatic send(input bit split, input int col);
    @(negedge clk);
    xfer_req = 1'b1; xfer_split = split; xfer_col = col[ADDR_W:0];
    @(negedge clk);
    xfer_req = 1'b0;
  endtask

  task automatic exp_full(input bit row);
    egen++;
    for (int i = 0; i < DEPTH; i++) emem[i] = {egen, row, i[7:0]};
  endtask

  task automatic exp_split(input bit half, input bit row);
    egen++;
    for (int i = 0; i < DEPTH; i++) if (i[7] == half) emem[i] = {egen, row, i[7:0]};
  endtask

  task automatic set_stop(input int code, input bit clr);
    @(negedge clk);
    stop_set = 1'b1; stop_code = code[STOP_W-1:0]; stop_clear = clr;
    @(negedge clk);
    stop_set = 1'b0; stop_clear = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(buf_addr == 0, "R1", buf_addr, 0);
    chk(half_flag == 1'b0, "R1", half_flag, 0);
    chk(!ld_valid && !split_err, "R1", {ld_valid, split_err}, 0);

    // R7 split before any full transfer
    send(1'b1, 9'd3);
    chk(split_err == 1'b1, "R7", split_err, 1);
    chk(ld_valid == 1'b0, "R7", ld_valid, 0);
    chk(buf_addr == 0, "R7", buf_addr, 0);

    // R2 full transfer, tap 125, row half high; R3 crossing 127->128
    send(1'b0, {1'b1, 8'd125});
    exp_full(1'b1);
    chk(buf_addr == 125, "R2", buf_addr, 125);
    chk(ld_valid && ld_full && ld_row_hi, "R2", {ld_valid, ld_full, ld_row_hi}, 7);
    for (int a = 126; a <= 129; a++) tick_exp(a, "R3");

    // R3 wrap 255->0
    send(1'b0, {1'b0, 8'd254});
    exp_full(1'b0);
    tick_exp(255, "R3");
    tick_exp(0, "R3");

    // R10 outputs released, pointer still advances
    @(negedge clk) ser_en_n = 1'b1;
    tick_exp(1, "R10");
    @(negedge clk) ser_en_n = 1'b0;
    tick_exp(2, "R10");

    // R4 split with column bit 7 set; R5 hop to loaded offset
    send(1'b0, {1'b0, 8'd120});
    exp_full(1'b0);
    tick_exp(121, "R3");
    send(1'b1, {1'b0, 1'b1, 7'd10});
    exp_split(1'b1, 1'b0);
    chk(ld_valid && !ld_full && ld_half && !ld_row_hi, "R4",
        {ld_valid, ld_full, ld_half, ld_row_hi}, 4'b1010);
    chk(buf_addr == 121, "R4", buf_addr, 121);
    for (int a = 122; a <= 127; a++) tick_exp(a, "R5");
    tick_exp(138, "R5");
    // R6 run out the high half, enter low half at offset 0
    for (int a = 139; a <= 255; a++) tick_exp(a, "R6");
    tick_exp(0, "R6");

    // R7 invalid offset 127
    send(1'b1, {1'b0, 1'b0, 7'd127});
    chk(split_err && !ld_valid, "R7", {split_err, ld_valid}, 2);
    chk(buf_addr == 0, "R7", buf_addr, 0);

    // R8 stop code 2: 32-word segments
    send(1'b1, {1'b0, 1'b0, 7'd5});
    exp_split(1'b1, 1'b0);
    set_stop(2, 1'b0);
    for (int a = 1; a <= 31; a++) tick_exp(a, "R8");
    tick_exp(133, "R8");
    for (int a = 134; a <= 159; a++) tick_exp(a, "R8");
    tick_exp(0, "R8");

    // R8 clamp of code 9 to 2-word segments
    set_stop(9, 1'b0);
    tick_exp(1, "R8");
    tick_exp(128, "R8");

    // R9 clear wins over a simultaneous set of code 3
    set_stop(3, 1'b1);
    for (int a = 129; a <= 160; a++) tick_exp(a, "R9");

    // R11 full transfer beats a same-cycle tick, and leaves split mode
    send(1'b1, {1'b0, 1'b0, 7'd9});
    exp_split(1'b0, 1'b0);
    chk(ld_valid && !ld_half, "R4", {ld_valid, ld_half}, 2);
    set_stop(2, 1'b0);
    begin
      exp_t it;
      it.addr = 8'd200; it.en = 1'b1; it.chk_data = 1'b0; it.tag = "R11";
      expq.push_back(it);
      @(negedge clk);
      xfer_req = 1'b1; xfer_split = 1'b0; xfer_col = {1'b0, 8'd200}; sclk_tick = 1'b1;
      @(negedge clk);
      xfer_req = 1'b0; sclk_tick = 1'b0;
      exp_full(1'b0);
      chk(ld_valid && ld_full, "R11", {ld_valid, ld_full}, 3);
    end
    send(1'b0, {1'b0, 8'd20});
    exp_full(1'b0);
    for (int a = 21; a <= 32; a++) tick_exp(a, "R11");

    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "scoreboard", expq.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule